// File: doc/BRIEF.md
# Directory Home-Node Coherence Controller

This block is the directory logic that sits at the home node of a shared-memory system. For every memory block it owns, it keeps a coherence state (Uncached, Shared or Exclusive) and a bit vector with one bit per processor node, marking which nodes hold a copy. Local nodes send it read-miss, write-miss and writeback requests over a valid/ready request channel.

For each request the controller looks up the block's entry and updates the state and the sharer vector. It then emits point-to-point messages only to the nodes whose copies must be invalidated or fetched. Nothing is broadcast. Messages leave one per handshake on a valid/ready outbound channel, each tagged with a message type, a target node and the block number. The controller accepts no new request while any message from the previous one is still waiting. This serializes all requests, including those to the same block. The number of nodes and blocks are parameters.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty sharer vector. Once the internal reset release completes, `req_ready` is high and `msg_valid` is low.
- R2: A read miss (`req_kind` 0) to an Uncached or Shared block emits no message. The block becomes Shared, and the requester is added to the sharers already present.
- R3: A write miss (`req_kind` 1) to a Shared block emits an invalidate (`msg_kind` 0) to every sharer except the requester. The block then becomes Exclusive, and the requester is its only sharer.
- R4: A write miss to an Uncached block emits no message. The block becomes Exclusive, owned by the requester.
- R5: A read miss to an Exclusive block emits a fetch (`msg_kind` 1) to the owner, unless the owner is the requester. The block becomes Shared, with both the owner's bit and the requester's bit set.
- R6: A write miss to an Exclusive block owned by another node emits a fetch-and-invalidate (`msg_kind` 2) to the old owner, and the requester becomes the owner. A write miss from the current owner emits nothing and leaves the block unchanged.
- R7: A writeback (`req_kind` 2) from the owner of an Exclusive block makes it Uncached and clears its sharer vector.
- R8: A writeback from a node that does not own the block as Exclusive is ignored. So is a request with `req_kind` 3. Neither changes the state or the sharers, and neither emits a message.
- R9: When one request produces several messages, they leave in ascending node order, one per cycle in which `msg_valid` and `msg_ready` are both high. While `msg_ready` is low, the message on the outbound channel stays stable. `req_ready` stays low until the last message has been taken.
- R10: Every message carries the requested block in `msg_block` and never targets the requesting node. Each block's entry evolves independently of the other blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 writeback, 3 no operation |
| req_node | input | $clog2(NODES) | Requesting node |
| req_block | input | $clog2(BLOCKS) | Block addressed by the request |
| msg_valid | output | 1 | Outbound message present |
| msg_ready | input | 1 | Network takes the message this cycle |
| msg_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate |
| msg_node | output | $clog2(NODES) | Node the message is sent to |
| msg_block | output | $clog2(BLOCKS) | Block the message concerns |

## Verification
The bench targets several cases where a wrong design would misbehave visibly.

- **Shared block with several sharers, one of them the requester.** A design that fails to mask the requester would send it an invalidate of its own line. A design that walks the vector in the wrong order would emit the right targets in a different sequence.
- **Writeback from a stale non-owner.** A design that accepted it would drop a live owner. The next write miss would then emit no fetch-and-invalidate where one is required.
- **Owner read-missing or write-missing its own block.** A careless design would fetch from the requester itself.
- **Outbound stalls.** Randomized `msg_ready` gaps catch a design that changes or drops a message while it waits, or that accepts a second request before the first one's messages have drained.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    DS_UNC = 2'd0,
    DS_SHR = 2'd1,
    DS_EXC = 2'd2
  } dir_state_e;

  typedef enum logic [1:0] {
    RQ_READ  = 2'd0,
    RQ_WRITE = 2'd1,
    RQ_WBACK = 2'd2,
    RQ_NOP   = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    MK_INV   = 2'd0,
    MK_FETCH = 2'd1,
    MK_FINV  = 2'd2
  } msg_kind_e;

endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  localparam int BW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    rd_blk,
  output dir_state_e       rd_state,
  output logic [NODES-1:0] rd_sharers,
  input  logic             wr_en,
  input  logic [BW-1:0]    wr_blk,
  input  dir_state_e       wr_state,
  input  logic [NODES-1:0] wr_sharers
);

  dir_state_e       st_all [BLOCKS];
  logic [NODES-1:0] sh_all [BLOCKS];

  for (genvar g = 0; g < BLOCKS; g++) begin : g_ent
    dir_state_e       st_q;
    logic [NODES-1:0] sh_q;
    logic             upd;

    assign upd = wr_en && (wr_blk == BW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= DS_UNC;
        sh_q <= '0;
      end else if (upd) begin
        st_q <= wr_state;
        sh_q <= wr_sharers;
      end
    end

    assign st_all[g] = st_q;
    assign sh_all[g] = sh_q;
  end

  always_comb begin
    rd_state   = DS_UNC;
    rd_sharers = '0;
    for (int b = 0; b < BLOCKS; b++) begin
      if (rd_blk == BW'(b)) begin
        rd_state   = st_all[b];
        rd_sharers = sh_all[b];
      end
    end
  end

endmodule

// File: rtl/dir_policy.sv
module dir_policy
  import dir_pkg::*;
#(
  parameter int NODES = 4,
  localparam int NW   = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic [1:0]       req_kind,
  input  logic [NW-1:0]    req_node,
  input  dir_state_e       cur_state,
  input  logic [NODES-1:0] cur_sharers,
  output logic             upd_en,
  output dir_state_e       nxt_state,
  output logic [NODES-1:0] nxt_sharers,
  output logic [NODES-1:0] targets,
  output logic [1:0]       out_kind
);

  logic [NODES-1:0] req_bit;
  logic [NODES-1:0] others;

  always_comb begin
    req_bit = '0;
    for (int i = 0; i < NODES; i++) begin
      if (req_node == NW'(i)) req_bit[i] = 1'b1;
    end
  end

  assign others = cur_sharers & ~req_bit;

  always_comb begin
    upd_en      = 1'b0;
    nxt_state   = cur_state;
    nxt_sharers = cur_sharers;
    targets     = '0;
    out_kind    = MK_INV;
    unique case (req_kind)
      RQ_READ: begin
        upd_en      = 1'b1;
        nxt_state   = DS_SHR;
        nxt_sharers = cur_sharers | req_bit;
        if (cur_state == DS_EXC) begin
          targets  = others;
          out_kind = MK_FETCH;
        end
      end
      RQ_WRITE: begin
        upd_en      = 1'b1;
        nxt_state   = DS_EXC;
        nxt_sharers = req_bit;
        if (cur_state == DS_SHR) begin
          targets  = others;
          out_kind = MK_INV;
        end else if (cur_state == DS_EXC) begin
          targets  = others;
          out_kind = MK_FINV;
        end
      end
      RQ_WBACK: begin
        if (cur_state == DS_EXC && (cur_sharers & req_bit) != '0) begin
          upd_en      = 1'b1;
          nxt_state   = DS_UNC;
          nxt_sharers = '0;
        end
      end
      default: begin
        upd_en = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/dir_msg_seq.sv
module dir_msg_seq #(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  localparam int NW    = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NODES-1:0] load_targets,
  input  logic [1:0]       load_kind,
  input  logic [BW-1:0]    load_blk,
  output logic             busy,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [1:0]       msg_kind,
  output logic [NW-1:0]    msg_node,
  output logic [BW-1:0]    msg_block
);

  logic [NODES-1:0] pend_q, pend_d;
  logic [1:0]       kind_q;
  logic [BW-1:0]    blk_q;
  logic [NW-1:0]    pick_idx;
  logic [NODES-1:0] pick_bit;
  logic             fire;

  // lowest pending node goes first
  always_comb begin
    pick_idx = '0;
    pick_bit = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        pick_idx = NW'(i);
        pick_bit = NODES'(1) << i;
      end
    end
  end

  assign busy      = |pend_q;
  assign msg_valid = busy;
  assign fire      = msg_valid && msg_ready;

  always_comb begin
    pend_d = pend_q;
    if (load)      pend_d = load_targets;
    else if (fire) pend_d = pend_q & ~pick_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= '0;
      blk_q  <= '0;
    end else if (load) begin
      kind_q <= load_kind;
      blk_q  <= load_blk;
    end
  end

  assign msg_kind  = kind_q;
  assign msg_node  = pick_idx;
  assign msg_block = blk_q;

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  localparam int NW    = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [NW-1:0] req_node,
  input  logic [BW-1:0] req_block,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [1:0]    msg_kind,
  output logic [NW-1:0] msg_node,
  output logic [BW-1:0] msg_block
);

  // reset: asserted at once, released on the second clock edge
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  dir_state_e       cur_state, nxt_state;
  logic [NODES-1:0] cur_sharers, nxt_sharers, targets;
  logic [1:0]       out_kind;
  logic             upd_en, busy, accept;

  assign req_ready = rst_sync && !busy;
  assign accept    = req_valid && req_ready;

  dir_entry_store #(.NODES(NODES), .BLOCKS(BLOCKS)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync),
    .rd_blk     (req_block),
    .rd_state   (cur_state),
    .rd_sharers (cur_sharers),
    .wr_en      (accept && upd_en),
    .wr_blk     (req_block),
    .wr_state   (nxt_state),
    .wr_sharers (nxt_sharers)
  );

  dir_policy #(.NODES(NODES)) u_policy (
    .req_kind    (req_kind),
    .req_node    (req_node),
    .cur_state   (cur_state),
    .cur_sharers (cur_sharers),
    .upd_en      (upd_en),
    .nxt_state   (nxt_state),
    .nxt_sharers (nxt_sharers),
    .targets     (targets),
    .out_kind    (out_kind)
  );

  dir_msg_seq #(.NODES(NODES), .BLOCKS(BLOCKS)) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync),
    .load         (accept && (targets != '0)),
    .load_targets (targets),
    .load_kind    (out_kind),
    .load_blk     (req_block),
    .busy         (busy),
    .msg_valid    (msg_valid),
    .msg_ready    (msg_ready),
    .msg_kind     (msg_kind),
    .msg_node     (msg_node),
    .msg_block    (msg_block)
  );

endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  localparam int NW    = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_kind,
  input logic [NW-1:0] req_node,
  input logic [BW-1:0] req_block,
  input logic          msg_valid,
  input logic          msg_ready,
  input logic [1:0]    msg_kind,
  input logic [NW-1:0] msg_node,
  input logic [BW-1:0] msg_block
);

  logic [NW-1:0] last_node;
  logic [BW-1:0] last_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_node <= '0;
      last_blk  <= '0;
    end else if (req_valid && req_ready) begin
      last_node <= req_node;
      last_blk  <= req_block;
    end
  end

  // R9
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_node) &&
                                   $stable(msg_kind) && $stable(msg_block)));

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !msg_valid);

  // R10
  no_self_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_node != last_node));

  // R10
  msg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_block == last_blk));

  // R9
  kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_kind != 2'd3));

endmodule

bind dir_home_ctrl dir_home_chk #(.NODES(NODES), .BLOCKS(BLOCKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_kind  (req_kind),
  .req_node  (req_node),
  .req_block (req_block),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_kind  (msg_kind),
  .msg_node  (msg_node),
  .msg_block (msg_block)
);

// File: tb/sim_dir_home_ctrl.sv
module sim_dir_home_ctrl;

  localparam int CLK_P  = 10;
  localparam int NODES  = 4;
  localparam int BLOCKS = 8;
  localparam int NW     = $clog2(NODES);
  localparam int BW     = $clog2(BLOCKS);

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_kind;
  logic [NW-1:0] req_node;
  logic [BW-1:0] req_block;
  logic          msg_valid;
  logic          msg_ready;
  logic [1:0]    msg_kind;
  logic [NW-1:0] msg_node;
  logic [BW-1:0] msg_block;

  dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS)) u0 (.*);

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit run = 0;
  bit done = 0;

  // stimulus queue
  int    s_kind[$], s_node[$], s_blk[$];
  string s_lbl[$];
  // expected outbound messages
  int    e_kind[$], e_node[$], e_blk[$];
  string e_lbl[$];
  string last_lbl = "R9";

  // model: 0 uncached, 1 shared, 2 exclusive
  int m_st[BLOCKS];
  bit [NODES-1:0] m_sh[BLOCKS];

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp_v, cyc);
    end
  endtask

  task automatic push_req(input int k, input int n, input int b, input string l);
    s_kind.push_back(k); s_node.push_back(n); s_blk.push_back(b); s_lbl.push_back(l);
  endtask

  task automatic model_apply(input int k, input int n, input int b, input string l);
    last_lbl = l;
    case (k)
      0: begin
        if (m_st[b] == 2) begin
          for (int i = 0; i < NODES; i++)
            if (m_sh[b][i] && i != n) begin
              e_kind.push_back(1); e_node.push_back(i); e_blk.push_back(b); e_lbl.push_back(l);
            end
        end
        m_st[b] = 1;
        m_sh[b][n] = 1'b1;
      end
      1: begin
        if (m_st[b] != 0) begin
          for (int i = 0; i < NODES; i++)
            if (m_sh[b][i] && i != n) begin
              e_kind.push_back(m_st[b] == 1 ? 0 : 2); e_node.push_back(i);
              e_blk.push_back(b); e_lbl.push_back(l);
            end
        end
        m_st[b] = 2;
        m_sh[b] = '0;
        m_sh[b][n] = 1'b1;
      end
      2: begin
        if (m_st[b] == 2 && m_sh[b][n]) begin
          m_st[b] = 0;
          m_sh[b] = '0;
        end
      end
      default: ;
    endcase
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // all checking and driving happens on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      finish_run();
    end
    if (run) begin
      // effect of the rising edge just passed
      if (e_kind.size() != 0) begin
        if (msg_ready) begin
          void'(e_kind.pop_front()); void'(e_node.pop_front());
          void'(e_blk.pop_front()); void'(e_lbl.pop_front());
        end
      end else if (req_valid) begin
        model_apply(s_kind[0], s_node[0], s_blk[0], s_lbl[0]);
        void'(s_kind.pop_front()); void'(s_node.pop_front());
        void'(s_blk.pop_front()); void'(s_lbl.pop_front());
      end
      // compare
      check(req_ready == (e_kind.size() == 0), "R9 req_ready", int'(req_ready),
            int'(e_kind.size() == 0));
      if (e_kind.size() != 0) begin
        check(msg_valid == 1'b1, {e_lbl[0], " msg_valid"}, int'(msg_valid), 1);
        if (msg_valid) begin
          check(int'(msg_kind) == e_kind[0], {e_lbl[0], " msg_kind"}, int'(msg_kind), e_kind[0]);
          check(int'(msg_node) == e_node[0], {e_lbl[0], " msg_node"}, int'(msg_node), e_node[0]);
          check(int'(msg_block) == e_blk[0], {e_lbl[0], " R10 msg_block"}, int'(msg_block), e_blk[0]);
        end
      end else begin
        check(msg_valid == 1'b0, {last_lbl, " unexpected msg"}, int'(msg_valid), 0);
      end
      // drive
      msg_ready = ((cyc * 7) % 5 != 0) && !(cyc % 13 == 4);
      if (s_kind.size() != 0) begin
        req_valid = 1'b1;
        req_kind  = 2'(s_kind[0]);
        req_node  = NW'(s_node[0]);
        req_block = BW'(s_blk[0]);
      end else begin
        req_valid = 1'b0;
      end
    end
  end

  initial begin
    int seed;
    req_valid = 1'b0;
    req_kind  = '0;
    req_node  = '0;
    req_block = '0;
    msg_ready = 1'b0;
    rst_n     = 1'b0;
    for (int b = 0; b < BLOCKS; b++) begin
      m_st[b] = 0;
      m_sh[b] = '0;
    end
    repeat (3) @(negedge clk);
    check(msg_valid == 1'b0, "R1 msg_valid in reset", int'(msg_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
    check(msg_valid == 1'b0, "R1 msg_valid after reset", int'(msg_valid), 0);

    // R1: first touch of any block behaves as Uncached
    push_req(1, 2, 3, "R1");
    push_req(0, 0, 1, "R2");
    push_req(0, 2, 1, "R2");
    push_req(1, 2, 1, "R3");
    push_req(0, 3, 1, "R5");
    push_req(1, 1, 1, "R3");
    push_req(1, 0, 1, "R6");
    push_req(1, 0, 1, "R6");
    push_req(0, 0, 1, "R5");
    push_req(1, 0, 1, "R3");
    push_req(2, 3, 1, "R8");
    push_req(1, 2, 1, "R8");
    push_req(2, 2, 1, "R7");
    push_req(1, 1, 1, "R7");
    push_req(1, 3, 5, "R4");
    push_req(0, 0, 5, "R5");
    push_req(0, 1, 6, "R2");
    push_req(0, 2, 6, "R2");
    push_req(3, 0, 6, "R8");
    push_req(1, 3, 6, "R8");
    push_req(0, 0, 7, "R10");
    push_req(1, 1, 0, "R10");
    push_req(1, 2, 7, "R10");
    push_req(0, 0, 0, "R10");
    push_req(0, 1, 6, "R9");
    push_req(0, 2, 6, "R9");
    push_req(0, 0, 6, "R9");
    push_req(1, 3, 6, "R9");
    seed = 12345;
    for (int i = 0; i < 300; i++) begin
      seed = seed * 1103515245 + 12345;
      push_req((seed >>> 8) & 3, (seed >>> 12) & (NODES - 1), (seed >>> 16) & (BLOCKS - 1),
               "R10 mix");
    end

    run = 1;
    wait (s_kind.size() == 0 && e_kind.size() == 0);
    repeat (6) @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule